// File: doc/BRIEF.md
# Split Ripple Binary Counter

This block is a four-bit counter divided into two sections that advance on their own count inputs. The low section is a single divide-by-two stage stepped by count input `cnt_a`; its state appears on `count_q[0]`. The high section is a three-stage divide-by-eight stepped by count input `cnt_b`; its state appears on `count_q[3:1]`. When the system outside the block routes `count_q[0]` back into `cnt_b`, the two sections chain into a full sixteen-state binary counter.

Both count inputs are treated as slow external waveforms. Each one is sampled on the system clock, and a section advances only when its sampled input has moved from high to low. The low section is a two-state machine with the states `HALF_LO` and `HALF_HI`. Each falling edge of `cnt_a` takes it along the transition `HALF_LO->HALF_HI` or `HALF_HI->HALF_LO`. The high section is an eight-state machine with the states `OCT_0` through `OCT_7`. Each falling edge of `cnt_b` takes it along the transition `OCT_n->OCT_n+1`. After `OCT_7` comes the wrap transition `OCT_7->OCT_0`. Both machines also have a clear transition `any->HALF_LO/OCT_0`, which is taken while both clear pins `clr_a` and `clr_b` are high.

Timing: a falling edge that is set up before clock edge n is seen by the sampling stage at edge n. The state then changes at edge n+1. This holds for the default sampling depth of one.

Top module: `split_ripple_counter`

## Requirements
- R1: While `rst_n` is low, and after it is released with no count edges applied, `count_q` is 4'b0000.
- R2: A high-to-low transition on `cnt_a` inverts `count_q[0]` and leaves `count_q[3:1]` unchanged. A low-to-high transition on `cnt_a` changes no output bit.
- R3: A high-to-low transition on `cnt_b` adds one, modulo 8, to `count_q[3:1]`, read as a binary number with `count_q[3]` as its most significant bit. It leaves `count_q[0]` unchanged.
- R4: With `cnt_b` driven from `count_q[0]`, successive falling edges on `cnt_a` step `count_q` through the binary values 0, 1, 2 and on up to 15. `count_q[3]` is the most significant bit and `count_q[0]` the least significant bit.
- R5: In the linked arrangement of R4, the falling edge on `cnt_a` that follows value 15 (4'b1111) returns `count_q` to 4'b0000. The high section alone likewise steps from 7 to 0.
- R6: When `clr_a` and `clr_b` are both high at a clock edge, all four bits of `count_q` are low after that edge.
- R7: When only one of `clr_a` and `clr_b` is high, the counter counts exactly as it does with both low.
- R8: While both clear pins are high, falling edges on `cnt_a` and `cnt_b` are ignored, and `count_q` stays 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the count inputs |
| rst_n | input | 1 | Active-low synchronous system reset |
| cnt_a | input | 1 | Count input of the divide-by-two section |
| cnt_b | input | 1 | Count input of the divide-by-eight section |
| clr_a | input | 1 | First clear pin; it acts only together with `clr_b` |
| clr_b | input | 1 | Second clear pin; it acts only together with `clr_a` |
| count_q | output | 4 | Counter state; bit 0 is the divide-by-two output, bits 3:1 are the divide-by-eight output |

## Verification
The hardest case to reach is the wrap of the full chain from 15 to 0. A single falling edge on `cnt_a` must ripple through the external link into a second falling edge on `cnt_b`, and that second edge must land on the `OCT_7->OCT_0` transition. The stimulus ties `cnt_b` to `count_q[0]` and applies twenty `cnt_a` pulses, which passes through the wrap and runs on beyond it. Each pulse is long enough for the linked edge to be sampled before the bench checks the outputs. The sections are then unlinked, so that each can be stepped separately. Finally, edges are applied while both clear pins are high, and again while only one of them is high.

// File: rtl/src_pkg.sv
package src_pkg;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_state_e;

    typedef enum logic [2:0] {
        OCT_0 = 3'd0,
        OCT_1 = 3'd1,
        OCT_2 = 3'd2,
        OCT_3 = 3'd3,
        OCT_4 = 3'd4,
        OCT_5 = 3'd5,
        OCT_6 = 3'd6,
        OCT_7 = 3'd7
    } oct_state_e;

    localparam int unsigned HIGH_BITS = 3;

endpackage

// File: rtl/fall_sense.sv
module fall_sense #(
    parameter int unsigned DEPTH = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);
    localparam int unsigned TOP = DEPTH - 1;

    logic [TOP:0] smp;
    logic         prev;

    for (genvar i = 0; i < DEPTH; i++) begin : g_smp
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) smp[0] <= 1'b0;
                else        smp[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) smp[i] <= 1'b0;
                else        smp[i] <= smp[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= smp[TOP];
    end

    assign fall = prev & ~smp[TOP];

    // R2: a detected fall lasts one cycle; the input must rise again before the next one
    p_single_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/half_stage.sv
module half_stage
    import src_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic q
);
    half_state_e cur, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) cur <= HALF_LO;
        else        cur <= nxt;
    end

    always_comb begin
        nxt = cur;
        if (clr) begin
            nxt = HALF_LO;
        end else if (adv) begin
            unique case (cur)
                HALF_LO: nxt = HALF_HI;
                HALF_HI: nxt = HALF_LO;
                default: nxt = HALF_LO;
            endcase
        end
    end

    always_comb begin
        unique case (cur)
            HALF_LO: q = 1'b0;
            HALF_HI: q = 1'b1;
            default: q = 1'b0;
        endcase
    end

    p_clear_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == 1'b0));
    p_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && adv) |=> (q != $past(q)));
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !adv) |=> $stable(q));

endmodule

// File: rtl/octal_stage.sv
module octal_stage
    import src_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 adv,
    output logic [HIGH_BITS-1:0] q
);
    oct_state_e cur, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) cur <= OCT_0;
        else        cur <= nxt;
    end

    always_comb begin
        nxt = cur;
        if (clr) begin
            nxt = OCT_0;
        end else if (adv) begin
            unique case (cur)
                OCT_0: nxt = OCT_1;
                OCT_1: nxt = OCT_2;
                OCT_2: nxt = OCT_3;
                OCT_3: nxt = OCT_4;
                OCT_4: nxt = OCT_5;
                OCT_5: nxt = OCT_6;
                OCT_6: nxt = OCT_7;
                OCT_7: nxt = OCT_0;
                default: nxt = OCT_0;
            endcase
        end
    end

    always_comb begin
        unique case (cur)
            OCT_0: q = 3'd0;
            OCT_1: q = 3'd1;
            OCT_2: q = 3'd2;
            OCT_3: q = 3'd3;
            OCT_4: q = 3'd4;
            OCT_5: q = 3'd5;
            OCT_6: q = 3'd6;
            OCT_7: q = 3'd7;
            default: q = 3'd0;
        endcase
    end

    p_clear_low_r6b: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == 3'd0));
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && adv && q != 3'd7) |=> (q == $past(q) + 3'd1));
    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && adv && q == 3'd7) |=> (q == 3'd0));
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !adv) |=> $stable(q));

endmodule

// File: rtl/split_ripple_counter.sv
module split_ripple_counter
    import src_pkg::*;
#(
    parameter int unsigned SAMPLE_DEPTH = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cnt_a,
    input  logic       cnt_b,
    input  logic       clr_a,
    input  logic       clr_b,
    output logic [3:0] count_q
);
    localparam int unsigned OUT_W = HIGH_BITS + 1;

    logic                 clr_both;
    logic                 fall_a;
    logic                 fall_b;
    logic                 low_q;
    logic [HIGH_BITS-1:0] high_q;

    assign clr_both = clr_a & clr_b;

    fall_sense #(.DEPTH(SAMPLE_DEPTH)) u_sense_a (
        .clk(clk), .rst_n(rst_n), .din(cnt_a), .fall(fall_a)
    );

    fall_sense #(.DEPTH(SAMPLE_DEPTH)) u_sense_b (
        .clk(clk), .rst_n(rst_n), .din(cnt_b), .fall(fall_b)
    );

    half_stage u_low (
        .clk(clk), .rst_n(rst_n), .clr(clr_both), .adv(fall_a), .q(low_q)
    );

    octal_stage u_high (
        .clk(clk), .rst_n(rst_n), .clr(clr_both), .adv(fall_b), .q(high_q)
    );

    assign count_q = OUT_W'({high_q, low_q});

    // R8: count edges during a joint clear leave the counter at zero
    p_clear_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_both && (fall_a || fall_b)) |=> (count_q == 4'd0));
    // R7: a lone clear pin does not stop the low section from counting
    p_lone_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_a ^ clr_b) && fall_a) |=> (count_q[0] != $past(count_q[0])));

endmodule

// File: tb/tb_split_ripple_counter.sv
module tb_split_ripple_counter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_a = 1'b0;
    logic       b_drv = 1'b0;
    logic       link = 1'b0;
    logic       clr_a = 1'b0;
    logic       clr_b = 1'b0;
    logic       cnt_b;
    logic [3:0] count_q;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    assign cnt_b = link ? count_q[0] : b_drv;

    split_ripple_counter dut (
        .clk(clk), .rst_n(rst_n), .cnt_a(cnt_a), .cnt_b(cnt_b),
        .clr_a(clr_a), .clr_b(clr_b), .count_q(count_q)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [3:0] exp);
        total++;
        if (count_q !== exp) begin
            bad++;
            $display("FAIL %s: count_q=%0d expected=%0d", req, count_q, exp);
        end
    endtask

    task automatic pulse_a();
        cnt_a = 1'b1; wait_cyc(8);
        cnt_a = 1'b0; wait_cyc(8);
    endtask

    task automatic pulse_b();
        b_drv = 1'b1; wait_cyc(8);
        b_drv = 1'b0; wait_cyc(8);
    endtask

    task automatic t_reset();
        wait_cyc(3);
        check("R1 during reset", 4'd0);
        rst_n = 1'b1;
        wait_cyc(4);
        check("R1 after reset", 4'd0);
    endtask

    task automatic t_linked();
        link = 1'b1;
        for (int k = 1; k <= 20; k++) begin
            pulse_a();
            if (k == 16) check("R5 wrap 15->0", 4'd0);
            else         check("R4 linked count", 4'(k % 16));
        end
        link = 1'b0;
    endtask

    task automatic t_separate();
        clr_a = 1'b1; clr_b = 1'b1; wait_cyc(3);
        clr_a = 1'b0; clr_b = 1'b0; wait_cyc(2);
        check("R6 clear before split test", 4'd0);
        for (int k = 1; k <= 3; k++) pulse_b();
        check("R3 high section alone", 4'd6);
        pulse_a();
        check("R2 low section alone", 4'd7);
        cnt_a = 1'b1; wait_cyc(8);
        check("R2 rising edge ignored", 4'd7);
        cnt_a = 1'b0; wait_cyc(8);
        check("R2 falling edge toggles", 4'd6);
        for (int k = 1; k <= 5; k++) pulse_b();
        check("R5 high section 3+5 wraps", 4'd0);
    endtask

    task automatic t_clear();
        pulse_a(); pulse_b(); pulse_b();
        check("R3 setup before clear", 4'd5);
        clr_a = 1'b1; clr_b = 1'b1; wait_cyc(2);
        check("R6 joint clear", 4'd0);
        pulse_a(); pulse_b();
        check("R8 edges ignored during clear", 4'd0);
        clr_a = 1'b0; clr_b = 1'b0; wait_cyc(8);
        check("R8 nothing counted after release", 4'd0);
    endtask

    task automatic t_lone_clear();
        clr_a = 1'b1;
        pulse_a();
        check("R7 clr_a alone, low section", 4'd1);
        clr_a = 1'b0; clr_b = 1'b1;
        pulse_b();
        check("R7 clr_b alone, high section", 4'd3);
        pulse_a();
        check("R7 clr_b alone, low section", 4'd2);
        clr_b = 1'b0;
    endtask

    initial begin
        t_reset();
        t_linked();
        t_separate();
        t_clear();
        t_lone_clear();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule